// File: doc/BRIEF.md
# Sorted Memory-Trace Consistency Checker

This block audits a memory access log after the fact. The log arrives one record per clock, already ordered by address and then by timestamp. Each record carries a cell address, a timestamp, a read/write flag and a cell of four data elements. The checker does not serve any memory traffic. It confirms two things: that the log really is in (address, timestamp) order, and that every read returns the cell value left by the latest earlier access to the same address.

Three sticky error flags report broken ordering, misaligned addresses and wrong read data. A saturating counter tallies the records that raise none of these conditions. Several records may share a timestamp, because the producer side can make up to three accesses per cycle at distinct addresses. The tracking state always follows the most recent valid record, including records that raised an error.

Top module: `mem_trace_checker`

## Requirements
- R1: After a synchronous reset, err_order, err_align and err_value are 0 and acc_count is 0.
- R2: A valid record whose address has either of its two low bits set raises err_align from the next cycle on.
- R3: A valid record at the same address as the previous valid record must carry a strictly greater timestamp; an equal or smaller timestamp raises err_order.
- R4: A valid record at a different address than the previous valid record must have a strictly greater address, and its timestamp may be anything; a smaller address raises err_order.
- R5: A valid read at the same address as the previous valid record must present data equal, on all four elements, to that record's cell value; any difference raises err_value.
- R6: A valid read at an address different from the previous valid record, or the first record after reset, must present an all-zero cell; anything else raises err_value.
- R7: A valid write never raises err_value, and its data becomes the cell value that a following read at the same address must match.
- R8: Every error flag, once set, stays set until reset, whatever records follow.
- R9: acc_count rises by one, one cycle after each valid record that raises none of the three conditions, and holds at its all-ones maximum instead of wrapping.
- R10: While rec_valid is 0 the other record inputs are ignored: no flag, the count and the tracked address, timestamp and cell value all stay unchanged.
- R11: The first valid record after reset passes the order check at any address and any timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_valid | input | 1 | A log record is present this cycle |
| rec_addr | input | ADDR_W | Cell address of the record |
| rec_stamp | input | STAMP_W | Timestamp of the record |
| rec_wr | input | 1 | 1 for a write, 0 for a read |
| rec_data | input | 4*ELEM_W | Four-element cell value, element 0 in the low bits |
| err_order | output | 1 | Sticky order error |
| err_align | output | 1 | Sticky alignment error |
| err_value | output | 1 | Sticky read-data error |
| acc_count | output | CNT_W | Saturating count of accepted records |

## Verification
The bench aims at the boundaries of the ordering rule. It uses an equal timestamp at a repeated address, which a design using a non-strict compare would let pass. It uses a timestamp that falls as the address rises, which a design comparing timestamps across addresses would flag by mistake. It also sends a read at a fresh address carrying stale data, which a design that keeps the old cell across an address change would accept. Idle cycles with bogus records check that nothing moves, and a narrow counter is driven past its maximum so that a wrapping counter shows as a drop to zero.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned CELL_N     = 4;
  localparam int unsigned ALIGN_BITS = 2;

  typedef struct packed {
    logic order_bad;
    logic align_bad;
    logic value_bad;
  } verdict_t;
endpackage

// File: rtl/mtc_order_cmp.sv
module mtc_order_cmp #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned STAMP_W = 16,
  parameter int unsigned LOW_W   = 2
) (
  input  logic               have_prev,
  input  logic [ADDR_W-1:0]  prev_addr,
  input  logic [STAMP_W-1:0] prev_stamp,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [STAMP_W-1:0] cur_stamp,
  output logic               same_addr,
  output logic               order_bad,
  output logic               align_bad
);
  function automatic logic seq_ok(input logic hp,
                                  input logic [ADDR_W-1:0] pa,
                                  input logic [STAMP_W-1:0] ps,
                                  input logic [ADDR_W-1:0] ca,
                                  input logic [STAMP_W-1:0] cs);
    if (!hp) return 1'b1;
    if (ca == pa) return cs > ps;
    return ca > pa;
  endfunction

  assign same_addr = have_prev && (cur_addr == prev_addr);
  assign order_bad = !seq_ok(have_prev, prev_addr, prev_stamp, cur_addr, cur_stamp);
  assign align_bad = |cur_addr[LOW_W-1:0];
endmodule

// File: rtl/mtc_cell_track.sv
module mtc_cell_track #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned STAMP_W = 16,
  parameter int unsigned DATA_W  = 124
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic               same_addr,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [STAMP_W-1:0] cur_stamp,
  input  logic               cur_wr,
  input  logic [DATA_W-1:0]  cur_data,
  output logic               have_prev,
  output logic [ADDR_W-1:0]  prev_addr,
  output logic [STAMP_W-1:0] prev_stamp,
  output logic [DATA_W-1:0]  exp_data
);
  logic [DATA_W-1:0] cell_q;

  function automatic logic [DATA_W-1:0] pick_expect(input logic same,
                                                    input logic [DATA_W-1:0] held);
    return same ? held : '0;
  endfunction

  assign exp_data = pick_expect(same_addr, cell_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev  <= 1'b0;
      prev_addr  <= '0;
      prev_stamp <= '0;
      cell_q     <= '0;
    end else if (upd) begin
      have_prev  <= 1'b1;
      prev_addr  <= cur_addr;
      prev_stamp <= cur_stamp;
      cell_q     <= cur_wr ? cur_data : exp_data;
    end
  end

  AST_TRACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(prev_addr) && $stable(prev_stamp) && $stable(cell_q))); // R10
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (upd && cur_wr) |=> (cell_q == $past(cur_data))); // R7
endmodule

// File: rtl/mtc_acc_count.sv
module mtc_acc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= sat_inc(count);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX)); // R9
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bump |=> $stable(count)); // R9
endmodule

// File: rtl/mem_trace_checker.sv
module mem_trace_checker
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned STAMP_W = 16,
  parameter int unsigned ELEM_W  = 31,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rec_valid,
  input  logic [ADDR_W-1:0]        rec_addr,
  input  logic [STAMP_W-1:0]       rec_stamp,
  input  logic                     rec_wr,
  input  logic [CELL_N*ELEM_W-1:0] rec_data,
  output logic                     err_order,
  output logic                     err_align,
  output logic                     err_value,
  output logic [CNT_W-1:0]         acc_count
);
  localparam int unsigned DATA_W = CELL_N * ELEM_W;

  logic               have_prev;
  logic [ADDR_W-1:0]  prev_addr;
  logic [STAMP_W-1:0] prev_stamp;
  logic [DATA_W-1:0]  exp_data;
  logic               same_addr;
  logic               cmp_order_bad;
  logic               cmp_align_bad;
  logic [CELL_N-1:0]  elem_eq;
  verdict_t           verdict;
  logic               rec_ok;

  mtc_order_cmp #(.ADDR_W(ADDR_W), .STAMP_W(STAMP_W), .LOW_W(ALIGN_BITS)) u_cmp (
    .have_prev (have_prev),
    .prev_addr (prev_addr),
    .prev_stamp(prev_stamp),
    .cur_addr  (rec_addr),
    .cur_stamp (rec_stamp),
    .same_addr (same_addr),
    .order_bad (cmp_order_bad),
    .align_bad (cmp_align_bad)
  );

  mtc_cell_track #(.ADDR_W(ADDR_W), .STAMP_W(STAMP_W), .DATA_W(DATA_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .upd       (rec_valid),
    .same_addr (same_addr),
    .cur_addr  (rec_addr),
    .cur_stamp (rec_stamp),
    .cur_wr    (rec_wr),
    .cur_data  (rec_data),
    .have_prev (have_prev),
    .prev_addr (prev_addr),
    .prev_stamp(prev_stamp),
    .exp_data  (exp_data)
  );

  for (genvar g = 0; g < CELL_N; g++) begin : g_elem
    assign elem_eq[g] = rec_data[g*ELEM_W +: ELEM_W] == exp_data[g*ELEM_W +: ELEM_W];
  end

  always_comb begin
    verdict.order_bad = rec_valid && cmp_order_bad;
    verdict.align_bad = rec_valid && cmp_align_bad;
    verdict.value_bad = rec_valid && !rec_wr && !(&elem_eq);
  end

  assign rec_ok = rec_valid && !(|verdict);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_order <= 1'b0;
      err_align <= 1'b0;
      err_value <= 1'b0;
    end else begin
      err_order <= err_order || verdict.order_bad;
      err_align <= err_align || verdict.align_bad;
      err_value <= err_value || verdict.value_bad;
    end
  end

  mtc_acc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .bump (rec_ok),
    .count(acc_count)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!err_order && !err_align && !err_value && acc_count == '0)); // R1
  AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_order |=> err_order); // R8
  AST_VALUE_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_value |=> err_value); // R8
  AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_align |=> err_align); // R8
  AST_FIRST_FREE: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !have_prev) |-> !cmp_order_bad); // R11
  AST_WRITE_NO_VAL: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_wr && !err_value) |=> !err_value); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rec_valid |=> ($stable(err_order) && $stable(err_align) && $stable(err_value))); // R10
endmodule

// File: tb/mem_trace_checker_test.sv
`timescale 1ns/1ps
module mem_trace_checker_test;
  localparam int unsigned AW = 16;
  localparam int unsigned TW = 16;
  localparam int unsigned EW = 31;
  localparam int unsigned CW = 6;
  localparam int unsigned DW = 4 * EW;
  localparam logic [CW-1:0] CMAX = '1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rec_valid = 1'b0;
  logic [AW-1:0] rec_addr = '0;
  logic [TW-1:0] rec_stamp = '0;
  logic          rec_wr = 1'b0;
  logic [DW-1:0] rec_data = '0;
  logic          err_order, err_align, err_value;
  logic [CW-1:0] acc_count;

  int n_checks = 0;
  int n_fail = 0;

  bit            m_has;
  logic [AW-1:0] m_addr;
  logic [TW-1:0] m_stamp;
  logic [DW-1:0] m_data;
  bit            m_ord, m_aln, m_val;
  logic [CW-1:0] m_cnt;

  always #2.5 clk = ~clk;

  mem_trace_checker #(.ADDR_W(AW), .STAMP_W(TW), .ELEM_W(EW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_addr(rec_addr),
    .rec_stamp(rec_stamp), .rec_wr(rec_wr), .rec_data(rec_data),
    .err_order(err_order), .err_align(err_align), .err_value(err_value),
    .acc_count(acc_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_cell();
    logic [DW-1:0] c;
    for (int i = 0; i < 4; i++) c[i*EW +: EW] = EW'($urandom);
    return c;
  endfunction

  function automatic logic [DW-1:0] read_expect(input logic [AW-1:0] a);
    return (m_has && a == m_addr) ? m_data : '0;
  endfunction

  task automatic model(input bit v, input logic [AW-1:0] a, input logic [TW-1:0] s,
                       input bit w, input logic [DW-1:0] d);
    logic [DW-1:0] ex;
    bit bo, ba, bv;
    if (!v) return;
    ex = read_expect(a);
    bo = m_has && ((a == m_addr) ? !(s > m_stamp) : !(a > m_addr));
    ba = (a[1:0] != 2'b00);
    bv = !w && (d != ex);
    m_ord = m_ord || bo;
    m_aln = m_aln || ba;
    m_val = m_val || bv;
    if (!bo && !ba && !bv && m_cnt != CMAX) m_cnt = m_cnt + 1'b1;
    m_has = 1'b1; m_addr = a; m_stamp = s;
    m_data = w ? d : ex;
  endtask

  task automatic check_all();
    chk("R3 R4 err_order", 32'(err_order), 32'(m_ord));
    chk("R2 err_align", 32'(err_align), 32'(m_aln));
    chk("R5 R6 err_value", 32'(err_value), 32'(m_val));
    chk("R9 acc_count", 32'(acc_count), 32'(m_cnt));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rec_valid = 1'b0;
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b0;
    m_has = 0; m_addr = '0; m_stamp = '0; m_data = '0;
    m_ord = 0; m_aln = 0; m_val = 0; m_cnt = '0;
    chk("R1 reset order", 32'(err_order), 0);
    chk("R1 reset align", 32'(err_align), 0);
    chk("R1 reset value", 32'(err_value), 0);
    chk("R1 reset count", 32'(acc_count), 0);
  endtask

  task automatic send(input bit v, input logic [AW-1:0] a, input logic [TW-1:0] s,
                      input bit w, input logic [DW-1:0] d);
    @(negedge clk);
    rec_valid = v; rec_addr = a; rec_stamp = s; rec_wr = w; rec_data = d;
    model(v, a, s, w, d);
    @(posedge clk); #1;
    rec_valid = 1'b0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] cd;
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R11 R6: first record anywhere, read of zero cell
    send(1, 16'd40, 16'd900, 0, '0);
    chk("R11 first record ok", 32'(err_order), 0);
    cd = rnd_cell();
    send(1, 16'd40, 16'd901, 1, cd);      // R7 write
    send(1, 16'd40, 16'd905, 0, cd);      // R5 matching read
    chk("R5 match read count", 32'(acc_count), 3);
    // R10: idle cycle carrying a bad record
    send(0, 16'd1, 16'd0, 0, rnd_cell());
    chk("R10 idle ignored", 32'(acc_count), 3);
    send(1, 16'd40, 16'd906, 0, cd);      // R10 state still intact
    chk("R10 cell kept", 32'(err_value), 0);
    send(1, 16'd44, 16'd2, 0, '0);        // R4 stamp may drop on new address
    chk("R4 stamp drop ok", 32'(err_order), 0);

    do_reset();                            // R3 equal stamp
    send(1, 16'd8, 16'd5, 1, rnd_cell());
    send(1, 16'd8, 16'd5, 1, rnd_cell());
    chk("R3 equal stamp flagged", 32'(err_order), 1);
    send(1, 16'd12, 16'd6, 0, '0);
    chk("R8 order sticky", 32'(err_order), 1);

    do_reset();                            // R4 lower address
    send(1, 16'd64, 16'd5, 0, '0);
    send(1, 16'd60, 16'd9, 0, '0);
    chk("R4 lower addr flagged", 32'(err_order), 1);

    do_reset();                            // R2 misaligned
    send(1, 16'd6, 16'd1, 1, rnd_cell());
    chk("R2 misaligned flagged", 32'(err_align), 1);

    do_reset();                            // R5 mismatch on one element
    cd = rnd_cell();
    send(1, 16'd20, 16'd1, 1, cd);
    cd[3*EW] = ~cd[3*EW];
    send(1, 16'd20, 16'd2, 0, cd);
    chk("R5 mismatch flagged", 32'(err_value), 1);
    send(1, 16'd24, 16'd3, 0, '0);
    chk("R8 value sticky", 32'(err_value), 1);

    do_reset();                            // R6 stale data at fresh address
    cd = rnd_cell();
    send(1, 16'd20, 16'd1, 1, cd);
    send(1, 16'd24, 16'd2, 0, cd);
    chk("R6 fresh addr nonzero flagged", 32'(err_value), 1);

    do_reset();                            // R9 saturation
    for (int i = 0; i < 70; i++) send(1, 16'd100, TW'(i + 1), 1, rnd_cell());
    chk("R9 saturated", 32'(acc_count), 32'(CMAX));

    for (int ph = 0; ph < 30; ph++) begin
      logic [AW-1:0] a;
      logic [TW-1:0] s;
      do_reset();
      a = AW'(($urandom % 64) * 4);
      s = TW'($urandom % 100);
      for (int k = 0; k < 50; k++) begin
        int r;
        bit w, v;
        logic [AW-1:0] ra;
        logic [DW-1:0] d;
        r = $urandom % 100;
        v = ($urandom % 100) >= 5;
        if (r < 55) begin s = s + TW'(1 + $urandom % 3); ra = a; end
        else if (r < 85) begin a = a + AW'(4 * (1 + $urandom % 3)); s = TW'($urandom % 200); ra = a; end
        else if (r < 90) begin ra = a; end
        else if (r < 94) begin ra = a - 16'd4; end
        else if (r < 97) begin ra = a + 16'd2; end
        else begin s = s + 1'b1; ra = a; end
        w = $urandom % 2;
        d = w ? rnd_cell() : read_expect(ra);
        if (!w && ($urandom % 100) < 6) d[EW*($urandom % 4)] ^= 1'b1;
        send(v, ra, s, w, d);
        if (v) a = ra;
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule